// File: doc/BRIEF.md
# Short I2C Transfer Sequencer

This block carries out a whole short I2C transaction, one to eight data bytes in either direction, from a single descriptor written by software. Software first loads up to eight outgoing bytes into two 32-bit data words and sets an interrupt mask. It then writes one control word that holds the target address, the direction, the 10-bit address flag, the byte counts and an enable flag. The sequencer takes a snapshot of that descriptor. It then drives a byte-level bus engine through a START, the address byte or bytes, the data bytes and a STOP, with no software action between bytes.

When the STOP has finished, a completion flag is raised and an error flag shows whether any address or data byte was refused. Bytes that were read arrive little-endian in two 32-bit receive words. The interrupt line is the completion flag gated by the mask. Software acknowledges by clearing the enable flag and writing zero to the completion flag. The byte engine sits outside this block. It accepts one command per pulse and answers with a one-cycle done pulse, a refusal flag and a read byte.

Top module: `tgen_offload`

## Requirements
- R1: After synchronous reset the completion flag, the error flag, the interrupt and both receive words are zero, and no engine command is issued.
- R2: Register selects are control=0, low transmit word=1, high transmit word=2, completion=3, mask=4. A transfer starts only when a control write sets bit 19 while the stored enable is 0 and the sequencer is idle. The descriptor is captured at that moment, and later control writes do not change or restart a running or finished transfer.
- R3: Engine commands use the op codes START=0, WRITE=1, READ=2, STOP=3. Each command is a one-cycle pulse, the next command follows only after the engine's done pulse, and every valid transfer runs START, the address bytes, the data bytes and then STOP.
- R4: When bit 12 is 0, the single address byte is control bits 8:2 followed by the direction bit as its LSB (1 = read).
- R5: When bit 12 is 1, the first address byte is binary 11110, then control bits 11:10, then the direction bit. The second address byte is control bits 9:2.
- R6: A write (bit 0 set, bit 1 clear) sends (bits 15:13)+1 bytes. Byte k is bits 8k+7:8k of the low transmit word for k<4 and of the high word for k>=4. Bits 18:16 are ignored.
- R7: A read (bit 1 set, bit 0 clear) performs (bits 18:16)+1 READ commands. The acknowledge flag is 1 (acknowledge) on every read except the last, where it is 0. Read byte k lands little-endian in the low receive word (k<4) or the high one. Bits 15:13 are ignored.
- R8: If the engine reports a refusal on any address or written data byte, the remaining bytes are skipped, STOP is issued at once, and the error flag is 1 at completion.
- R9: If control bits 0 and 1 are both set or both clear, no engine command is issued, and completion is raised with the error flag set.
- R10: Completion sets the completion flag in the cycle after the STOP's done pulse. The error flag is 0 after a clean transfer and is cleared at each launch. The interrupt always equals completion AND mask.
- R11: Writing zero to the completion register clears the flag, and writing one leaves it unchanged. The sequencer stays finished, and cannot be relaunched, until the stored enable is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register select |
| reg_wdata | input | 32 | Register write data |
| rx_lo | output | 32 | Received bytes 0 to 3 |
| rx_hi | output | 32 | Received bytes 4 to 7 |
| done_cause | output | 1 | Completion flag |
| xfer_err | output | 1 | Error flag of the last transfer |
| irq | output | 1 | Interrupt, completion gated by mask |
| eng_cmd_valid | output | 1 | Engine command pulse |
| eng_cmd_op | output | 2 | Engine command op code |
| eng_cmd_data | output | 8 | Byte to send on WRITE |
| eng_cmd_ack | output | 1 | Acknowledge flag for READ |
| eng_done | input | 1 | Engine finished the current command |
| eng_nack | input | 1 | Slave refused the written byte |
| eng_rdata | input | 8 | Byte returned by READ |

## Verification
The bench targets the one-byte read, which must refuse its only byte. A design that mishandled the final-byte acknowledge would keep acknowledging and hold the slave on the bus. Eight-byte transfers in both directions exercise the switch to the high word. A wrong lane select would repeat the low word or shift the bytes. Refusals at the address and in the middle of the data must cut the byte stream short with an error, and a design that ignored them would send extra WRITE commands. The bench also rewrites the control word in the middle of a transfer and again after it finishes, and tries both illegal direction patterns. A design without a descriptor snapshot or an idle gate would change the address on the fly, start a second transfer, or touch the bus on a malformed descriptor.

// File: rtl/tgen_pkg.sv
package tgen_pkg;
    localparam int WORD_W   = 32;
    localparam int BYTE_W   = 8;
    localparam int NBYTES   = 2 * WORD_W / BYTE_W;
    localparam int IDX_W    = $clog2(NBYTES);
    localparam int ADDR_W   = 10;

    localparam int B_WR     = 0;
    localparam int B_RD     = 1;
    localparam int B_ADDR   = 2;
    localparam int B_EXT    = 12;
    localparam int B_TXN    = 13;
    localparam int B_RXN    = 16;
    localparam int B_EN     = 19;

    typedef enum logic [1:0] {
        OP_START = 2'd0,
        OP_WRITE = 2'd1,
        OP_READ  = 2'd2,
        OP_STOP  = 2'd3
    } bus_op_e;

    typedef enum logic [2:0] {
        RS_CTRL  = 3'd0,
        RS_TXLO  = 3'd1,
        RS_TXHI  = 3'd2,
        RS_CAUSE = 3'd3,
        RS_MASK  = 3'd4
    } reg_sel_e;

    typedef enum logic [2:0] {
        SQ_IDLE, SQ_START, SQ_ADDR_HI, SQ_ADDR_LO, SQ_DATA, SQ_STOP, SQ_DONE
    } seq_state_e;

    typedef struct packed {
        logic                  is_read;
        logic                  ext;
        logic [ADDR_W-1:0]     addr;
        logic [IDX_W-1:0]      last;
        logic [2*WORD_W-1:0]   tx;
    } job_t;

    function automatic logic [BYTE_W-1:0] lead_addr_byte(job_t j);
        if (j.ext)
            return {5'b11110, j.addr[9:8], j.is_read};
        return {j.addr[6:0], j.is_read};
    endfunction

    function automatic logic [BYTE_W-1:0] tx_lane(logic [2*WORD_W-1:0] w,
                                                  logic [IDX_W-1:0] k);
        return w[{k, 3'b000} +: BYTE_W];
    endfunction
endpackage

// File: rtl/tgen_regs.sv
module tgen_regs
    import tgen_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic [2:0]        reg_sel,
    input  logic [WORD_W-1:0] reg_wdata,
    input  logic              seq_idle,
    input  logic              fin,
    input  logic              fin_err,
    output logic              launch,
    output logic              launch_bad,
    output job_t              job,
    output logic              en_q,
    output logic              cause,
    output logic              err,
    output logic              irq
);
    logic [WORD_W-1:0] tx_lo_q, tx_hi_q;
    logic              mask_q;
    reg_sel_e          sel;

    assign sel        = reg_sel_e'(reg_sel);
    assign launch     = reg_wr && (sel == RS_CTRL) && reg_wdata[B_EN] && !en_q && seq_idle;
    assign launch_bad = reg_wdata[B_WR] == reg_wdata[B_RD];

    always_comb begin
        job.is_read = reg_wdata[B_RD];
        job.ext     = reg_wdata[B_EXT];
        job.addr    = reg_wdata[B_ADDR +: ADDR_W];
        job.last    = reg_wdata[B_RD] ? reg_wdata[B_RXN +: IDX_W] : reg_wdata[B_TXN +: IDX_W];
        job.tx      = {tx_hi_q, tx_lo_q};
    end

    assign irq = cause & mask_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q    <= 1'b0;
            tx_lo_q <= '0;
            tx_hi_q <= '0;
            mask_q  <= 1'b0;
            cause   <= 1'b0;
            err     <= 1'b0;
        end else begin
            if (reg_wr) begin
                case (sel)
                    RS_CTRL:  en_q    <= reg_wdata[B_EN];
                    RS_TXLO:  tx_lo_q <= reg_wdata;
                    RS_TXHI:  tx_hi_q <= reg_wdata;
                    RS_CAUSE: cause   <= cause & reg_wdata[0];
                    RS_MASK:  mask_q  <= reg_wdata[0];
                    default: ;
                endcase
            end
            if (fin) begin
                cause <= 1'b1;
                err   <= fin_err;
            end else if (launch) begin
                err   <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/tgen_seq.sv
module tgen_seq
    import tgen_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              launch,
    input  logic              launch_bad,
    input  job_t              job_in,
    input  logic              en_q,
    input  logic              eng_done,
    input  logic              eng_nack,
    output logic              cmd_valid,
    output bus_op_e           cmd_op,
    output logic [BYTE_W-1:0] cmd_data,
    output logic              cmd_ack,
    output logic              idle,
    output logic              in_done,
    output logic              fin,
    output logic              fin_err,
    output logic              rx_we,
    output logic [IDX_W-1:0]  rx_idx
);
    seq_state_e       state;
    job_t             job_q;
    logic [IDX_W-1:0] idx;
    logic             issued, err_q, step, on_bus;

    assign on_bus    = (state != SQ_IDLE) && (state != SQ_DONE);
    assign cmd_valid = on_bus && !issued;
    assign step      = issued && eng_done;
    assign idle      = state == SQ_IDLE;
    assign in_done   = state == SQ_DONE;
    assign fin       = ((state == SQ_STOP) && step) || (launch && launch_bad);
    assign fin_err   = (state == SQ_STOP) ? err_q : 1'b1;
    assign rx_we     = (state == SQ_DATA) && job_q.is_read && step;
    assign rx_idx    = idx;

    always_comb begin
        cmd_op   = OP_STOP;
        cmd_data = '0;
        cmd_ack  = 1'b0;
        case (state)
            SQ_START:   cmd_op = OP_START;
            SQ_ADDR_HI: begin cmd_op = OP_WRITE; cmd_data = lead_addr_byte(job_q); end
            SQ_ADDR_LO: begin cmd_op = OP_WRITE; cmd_data = job_q.addr[7:0]; end
            SQ_DATA: begin
                if (job_q.is_read) begin
                    cmd_op  = OP_READ;
                    cmd_ack = idx != job_q.last;
                end else begin
                    cmd_op   = OP_WRITE;
                    cmd_data = tx_lane(job_q.tx, idx);
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= SQ_IDLE;
            job_q  <= '0;
            idx    <= '0;
            issued <= 1'b0;
            err_q  <= 1'b0;
        end else begin
            if (cmd_valid) issued <= 1'b1;
            if (step)      issued <= 1'b0;
            case (state)
                SQ_IDLE: begin
                    if (launch) begin
                        if (launch_bad) begin
                            state <= SQ_DONE;
                        end else begin
                            state <= SQ_START;
                            job_q <= job_in;
                            idx   <= '0;
                            err_q <= 1'b0;
                        end
                    end
                end
                SQ_DONE: if (!en_q) state <= SQ_IDLE;
                SQ_START: if (step) state <= SQ_ADDR_HI;
                SQ_ADDR_HI: if (step) begin
                    if (eng_nack) begin
                        err_q <= 1'b1;
                        state <= SQ_STOP;
                    end else begin
                        state <= job_q.ext ? SQ_ADDR_LO : SQ_DATA;
                    end
                end
                SQ_ADDR_LO: if (step) begin
                    if (eng_nack) begin
                        err_q <= 1'b1;
                        state <= SQ_STOP;
                    end else begin
                        state <= SQ_DATA;
                    end
                end
                SQ_DATA: if (step) begin
                    if (!job_q.is_read && eng_nack) begin
                        err_q <= 1'b1;
                        state <= SQ_STOP;
                    end else if (idx == job_q.last) begin
                        state <= SQ_STOP;
                    end else begin
                        idx <= idx + 1'b1;
                    end
                end
                SQ_STOP: if (step) state <= SQ_DONE;
                default: state <= SQ_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/tgen_rxpack.sv
module tgen_rxpack
    import tgen_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [IDX_W-1:0]  idx,
    input  logic [BYTE_W-1:0] din,
    output logic [WORD_W-1:0] rx_lo,
    output logic [WORD_W-1:0] rx_hi
);
    logic [NBYTES*BYTE_W-1:0] lanes;

    for (genvar i = 0; i < NBYTES; i++) begin : g_lane
        always_ff @(posedge clk) begin
            if (rst)
                lanes[i*BYTE_W +: BYTE_W] <= '0;
            else if (we && (idx == IDX_W'(i)))
                lanes[i*BYTE_W +: BYTE_W] <= din;
        end
    end

    assign rx_lo = lanes[WORD_W-1:0];
    assign rx_hi = lanes[2*WORD_W-1:WORD_W];
endmodule

// File: rtl/tgen_offload.sv
module tgen_offload
    import tgen_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        reg_wr,
    input  logic [2:0]  reg_sel,
    input  logic [31:0] reg_wdata,
    output logic [31:0] rx_lo,
    output logic [31:0] rx_hi,
    output logic        done_cause,
    output logic        xfer_err,
    output logic        irq,
    output logic        eng_cmd_valid,
    output logic [1:0]  eng_cmd_op,
    output logic [7:0]  eng_cmd_data,
    output logic        eng_cmd_ack,
    input  logic        eng_done,
    input  logic        eng_nack,
    input  logic [7:0]  eng_rdata
);
    logic             launch, launch_bad, en_q, seq_idle, seq_done, fin, fin_err, rx_we;
    logic [IDX_W-1:0] rx_idx;
    job_t             job;
    bus_op_e          op;

    assign eng_cmd_op = op;

    tgen_regs u_regs (
        .clk, .rst, .reg_wr, .reg_sel, .reg_wdata,
        .seq_idle, .fin, .fin_err,
        .launch, .launch_bad, .job, .en_q,
        .cause(done_cause), .err(xfer_err), .irq
    );

    tgen_seq u_seq (
        .clk, .rst, .launch, .launch_bad, .job_in(job), .en_q,
        .eng_done, .eng_nack,
        .cmd_valid(eng_cmd_valid), .cmd_op(op), .cmd_data(eng_cmd_data), .cmd_ack(eng_cmd_ack),
        .idle(seq_idle), .in_done(seq_done), .fin, .fin_err, .rx_we, .rx_idx
    );

    tgen_rxpack u_rx (
        .clk, .rst, .we(rx_we), .idx(rx_idx), .din(eng_rdata), .rx_lo, .rx_hi
    );
endmodule

// File: rtl/tgen_offload_chk.sv
module tgen_offload_chk (
    input logic       clk,
    input logic       rst,
    input logic       reg_wr,
    input logic [2:0] reg_sel,
    input logic       eng_cmd_valid,
    input logic       done_cause,
    input logic       seq_idle,
    input logic       seq_done
);
    // R3: every command is a single-cycle pulse
    a_r3_cmd_pulse: assert property (@(posedge clk) disable iff (rst)
        eng_cmd_valid |=> !eng_cmd_valid);

    // R11: completion only falls through a completion-register write
    a_r11_cause_sticky: assert property (@(posedge clk) disable iff (rst)
        (done_cause && !(reg_wr && reg_sel == 3'd3)) |=> done_cause);

    // R2: the idle sequencer leaves idle only on a register write
    a_r2_idle_hold: assert property (@(posedge clk) disable iff (rst)
        (seq_idle && !reg_wr) |=> seq_idle);

    // R10: completion rises only after bus work or a launch attempt
    a_r10_cause_origin: assert property (@(posedge clk) disable iff (rst)
        $rose(done_cause) |-> (seq_done && ($past(!seq_idle) || $past(reg_wr))));
endmodule

bind tgen_offload tgen_offload_chk u_chk (
    .clk, .rst, .reg_wr, .reg_sel, .eng_cmd_valid, .done_cause,
    .seq_idle, .seq_done
);

// File: tb/tgen_offload_bench.sv
`timescale 1ns/1ps
module tgen_offload_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_sel = 3'd0;
    logic [31:0] reg_wdata = 32'd0;
    logic [31:0] rx_lo, rx_hi;
    logic        done_cause, xfer_err, irq;
    logic        eng_cmd_valid, eng_cmd_ack;
    logic [1:0]  eng_cmd_op;
    logic [7:0]  eng_cmd_data;
    logic        eng_done = 1'b0, eng_nack = 1'b0;
    logic [7:0]  eng_rdata = 8'd0;

    always #2.5 clk = ~clk;

    tgen_offload u_tgen_offload (
        .clk, .rst, .reg_wr, .reg_sel, .reg_wdata, .rx_lo, .rx_hi,
        .done_cause, .xfer_err, .irq, .eng_cmd_valid, .eng_cmd_op,
        .eng_cmd_data, .eng_cmd_ack, .eng_done, .eng_nack, .eng_rdata
    );

    typedef struct {
        logic [1:0] op;
        logic [7:0] d;
        bit         ack;
        bit         chkd;
        string      tag;
    } ecmd_t;

    ecmd_t exp_q[$];
    int    n_cmp = 0, n_bad = 0;
    bit    mask_sh = 1'b0, ended = 1'b0;
    int    e_cnt = 0, nack_at = -1, rd_k = 0, e_wait = 0;
    bit    e_busy = 1'b0, e_nack = 1'b0;
    logic [7:0] seed = 8'h00, e_rd = 8'h00;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // bus-level engine model and per-clock comparison
    always @(negedge clk) begin
        eng_done = 1'b0;
        eng_nack = 1'b0;
        if (!rst) check(irq == (done_cause & mask_sh), "R10", "irq per clock", irq, done_cause & mask_sh);
        if (e_busy) begin
            if (e_wait == 0) begin
                eng_done  = 1'b1;
                eng_nack  = e_nack;
                eng_rdata = e_rd;
                e_busy    = 1'b0;
            end else begin
                e_wait--;
            end
        end
        if (!rst && eng_cmd_valid) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R2", "unexpected command", eng_cmd_op, 0);
            end else begin
                ecmd_t x;
                x = exp_q.pop_front();
                check(eng_cmd_op == x.op, x.tag, "command op", eng_cmd_op, x.op);
                if (x.chkd) check(eng_cmd_data == x.d, x.tag, "command byte", eng_cmd_data, x.d);
                if (x.op == 2'd2) check(eng_cmd_ack == x.ack, "R7", "read acknowledge", eng_cmd_ack, x.ack);
            end
            e_nack = (eng_cmd_op == 2'd1) && (e_cnt == nack_at);
            e_rd   = seed + 8'(rd_k * 8'h11);
            if (eng_cmd_op == 2'd2) rd_k++;
            e_cnt++;
            e_busy = 1'b1;
            e_wait = 2;
        end
    end

    task automatic wr_reg(input logic [2:0] s, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_sel = s; reg_wdata = d;
        @(posedge clk);
        #1;
        reg_wr = 1'b0;
        if (s == 3'd4) mask_sh = d[0];
    endtask

    function automatic logic [31:0] mk_ctrl(bit rd, bit wr, bit ten, logic [9:0] a, int n);
        logic [31:0] c = 32'd0;
        c[0] = wr; c[1] = rd; c[11:2] = a; c[12] = ten; c[19] = 1'b1;
        c[15:13] = rd ? ~3'(n - 1) : 3'(n - 1);
        c[18:16] = rd ? 3'(n - 1) : ~3'(n - 1);
        return c;
    endfunction

    function automatic void push(logic [1:0] op, logic [7:0] d, bit ack, bit chkd, string tag);
        ecmd_t x;
        x.op = op; x.d = d; x.ack = ack; x.chkd = chkd; x.tag = tag;
        exp_q.push_back(x);
    endfunction

    task automatic run(input bit rd, input bit wr, input bit ten, input logic [9:0] a,
                       input int n, input logic [63:0] tx, input int nk, input bit poke,
                       input bit relaunch, input bit msk, input logic [7:0] sd);
        logic [31:0] ctrl;
        bit bad, nacked, got;
        int ci;
        ctrl = mk_ctrl(rd, wr, ten, a, n);
        bad = (rd == wr);
        nacked = 1'b0;
        wr_reg(3'd1, tx[31:0]);
        wr_reg(3'd2, tx[63:32]);
        wr_reg(3'd4, {31'd0, msk});
        if (!bad) begin
            push(2'd0, 8'd0, 1'b0, 1'b0, "R3");
            push(2'd1, ten ? {5'b11110, a[9:8], rd} : {a[6:0], rd}, 1'b0, 1'b1, ten ? "R5" : "R4");
            ci = 1;
            if (nk == 1) nacked = 1'b1;
            if (!nacked && ten) begin
                push(2'd1, a[7:0], 1'b0, 1'b1, "R5");
                ci = 2;
                if (nk == 2) nacked = 1'b1;
            end
            if (!nacked) begin
                for (int k = 0; k < n; k++) begin
                    ci++;
                    if (rd) push(2'd2, 8'd0, k != n - 1, 1'b0, "R7");
                    else    push(2'd1, tx[8*k +: 8], 1'b0, 1'b1, "R6");
                    if (!rd && nk == ci) begin nacked = 1'b1; break; end
                end
            end
            push(2'd3, 8'd0, 1'b0, 1'b0, nacked ? "R8" : "R3");
        end
        e_cnt = 0; rd_k = 0; nack_at = nk; seed = sd;
        wr_reg(3'd0, ctrl);
        if (poke) begin
            repeat (3) @(negedge clk);
            wr_reg(3'd0, ctrl ^ 32'h0000_0FFC);
        end
        got = 1'b0;
        for (int t = 0; t < 400; t++) begin
            @(negedge clk);
            if (done_cause) begin got = 1'b1; break; end
        end
        check(got, "R10", "completion raised", got, 1);
        check(exp_q.size() == 0, "R3", "commands outstanding", exp_q.size(), 0);
        exp_q.delete();
        check(xfer_err == (bad || nacked), bad ? "R9" : (nacked ? "R8" : "R10"),
              "error flag", xfer_err, bad || nacked);
        if (rd && !bad && !nacked) begin
            for (int k = 0; k < n; k++) begin
                logic [7:0] gb, eb;
                gb = (k < 4) ? rx_lo[8*k +: 8] : rx_hi[8*(k-4) +: 8];
                eb = sd + 8'(k * 8'h11);
                check(gb == eb, "R7", "received byte", gb, eb);
            end
        end
        check(irq == msk, "R10", "irq at completion", irq, msk);
        if (relaunch) begin
            wr_reg(3'd0, ctrl);
            wr_reg(3'd3, 32'd1);
            repeat (20) @(negedge clk);
            check(done_cause == 1'b1, "R11", "completion kept after write of one", done_cause, 1);
        end
        wr_reg(3'd0, 32'd0);
        wr_reg(3'd3, 32'd0);
        @(negedge clk);
        check(done_cause == 1'b0, "R11", "completion cleared", done_cause, 0);
        check(irq == 1'b0, "R11", "irq cleared", irq, 0);
    endtask

    task automatic report();
        if (!ended) begin
            ended = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        check(1'b0, "R3", "watchdog expired", 0, 1);
        report();
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check(done_cause == 1'b0, "R1", "completion after reset", done_cause, 0);
        check(xfer_err == 1'b0, "R1", "error after reset", xfer_err, 0);
        check(irq == 1'b0, "R1", "irq after reset", irq, 0);
        check(rx_lo == 32'd0 && rx_hi == 32'd0, "R1", "receive words after reset", rx_lo, 0);
        check(eng_cmd_valid == 1'b0, "R1", "no command after reset", eng_cmd_valid, 0);
        repeat (10) @(negedge clk);

        // 7-bit write, three bytes
        run(0, 1, 0, 10'h052, 3, 64'h0011_2233_4455_6677, -1, 0, 0, 1, 8'h00);
        // 7-bit write, eight bytes spanning both words
        run(0, 1, 0, 10'h07F, 8, 64'h8877_6655_4433_2211, -1, 0, 0, 1, 8'h00);
        // single-byte read: only byte is refused by the master
        run(1, 0, 0, 10'h023, 1, 64'd0, -1, 0, 0, 0, 8'h5A);
        // eight-byte read with 10-bit address
        run(1, 0, 1, 10'h2C6, 8, 64'd0, -1, 0, 0, 1, 8'h13);
        // 10-bit write, two bytes
        run(0, 1, 1, 10'h1A5, 2, 64'h0000_0000_0000_BEEF, -1, 0, 0, 1, 8'h00);
        // R8 refusal at the address byte
        run(0, 1, 0, 10'h011, 4, 64'h0000_0000_CAFE_F00D, 1, 0, 0, 1, 8'h00);
        // R8 refusal on the third data byte of five
        run(0, 1, 0, 10'h044, 5, 64'h0000_00AA_BBCC_DDEE, 4, 0, 0, 1, 8'h00);
        // R9 both direction bits and neither
        run(1, 1, 0, 10'h010, 2, 64'd0, -1, 0, 0, 1, 8'h00);
        run(0, 0, 0, 10'h010, 2, 64'd0, -1, 0, 0, 1, 8'h00);
        // R2 control rewrite mid-transfer, R11 relaunch attempt while finished, masked irq
        run(1, 0, 0, 10'h03C, 4, 64'd0, -1, 1, 1, 0, 8'h40);
        run(0, 1, 0, 10'h066, 6, 64'h0000_1234_5678_9ABC, -1, 1, 1, 1, 8'h00);

        repeat (5) @(negedge clk);
        report();
    end
endmodule